// File: doc/BRIEF.md
# Banked Mode Register File

This block holds the architectural registers of a 32-bit core that runs in seven operating modes. A 4-bit register index and the current mode together select a physical storage slot. Indexes 0 to 7 and the program counter always reach one shared copy. Indexes 8 to 12 have a second copy that only fast-interrupt mode uses. Indexes 13 and 14 have one copy shared by user and system modes, and a private copy for each of the five exception modes. Read ports are combinational. The single write port commits at the clock edge, using the mode that is current at that edge.

The block also holds the current status word, which carries condition flags, two interrupt masks, an instruction-set state bit and a 5-bit mode field. Each of the five exception modes has its own saved-status register. An exception-entry request copies the status word into the target mode's saved-status register, switches the mode and masks interrupts. A software write to the status word can change the flags in any mode. It can change the masks and the mode only in a privileged mode. The state bit follows a dedicated branch-exchange input only.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3: supervisor mode (mode field 0x13), both interrupt masks set, state bit clear, flags clear. Every register reads zero.
- R2: Indexes 0 to 7 and index 15 reach the same storage in every mode.
- R3: Indexes 8 to 12 reach a private copy in fast-interrupt mode (0x11). Every other mode shares one copy.
- R4: Indexes 13 and 14 are shared between user (0x10) and system (0x1F) modes. Fast interrupt (0x11), interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) each own a private pair.
- R5: A status write with the flag select set loads bits 31:28 into the flags in every mode, user mode included.
- R6: In user mode, a status write with the control select set leaves bit 7 (interrupt mask), bit 6 (fast-interrupt mask) and the mode field bits 4:0 unchanged.
- R7: In a privileged mode, a control write loads both mask bits. It loads the mode field only when the value is one of the seven mode codes, and otherwise keeps the old mode.
- R8: Bit 5, the state bit, ignores every status write and takes the branch-exchange value when that input is strobed.
- R9: An exception entry to one of the five exception modes copies the old status word into that mode's saved-status register, loads the target mode and sets bit 7. It also sets bit 6 when the target is fast interrupt, and leaves bit 6 unchanged otherwise. A mode change made by a software status write copies nothing.
- R10: The saved-status output reads zero in user and system modes. In the other modes it shows that mode's own saved-status register.
- R11: An exception request whose target is not an exception mode is ignored. An accepted exception takes precedence over a status write and a branch-exchange in the same cycle, and both of those are dropped.
- R12: Status bits 27:8 always read zero.
- R13: A register write in the same cycle as a mode change lands in the bank of the mode that was current before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx_i | input | NUM_RD*4 | Register index for each read port, port 0 in the low bits |
| rd_data_o | output | NUM_RD*DATA_W | Read data for each read port, combinational |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Register write index |
| wr_data_i | input | DATA_W | Register write data |
| psr_wr_flags_i | input | 1 | Status write, flag select |
| psr_wr_ctrl_i | input | 1 | Status write, mask and mode select |
| psr_wr_data_i | input | 32 | Status write data |
| exc_req_i | input | 1 | Exception-entry request |
| exc_mode_i | input | 5 | Target mode of the exception entry |
| bx_en_i | input | 1 | Branch-exchange strobe |
| bx_state_i | input | 1 | New state-bit value |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved-status register of the current mode, zero in user and system |

## Verification
Register traffic is driven through a tour of modes: supervisor, fast interrupt, system, interrupt and back. The same index is written in one mode and read in another, which tells shared storage from banked storage and tells a shared copy apart from a private one. Status writes are repeated in system and in user mode with legal and illegal mode codes and with the state bit set in the data, which separates the privileged path from the masked one. Exception entries are issued alone, next to a software mode change, and in the same cycle as a status write and a branch-exchange. These show that only real entries save status and that entries win collisions.

// File: rtl/bankrf_pkg.sv
// Package: shared mode codes, status bit positions and mode-decoding
// helpers for the banked register file.
// Assumes a fixed 32-bit status word and seven architectural modes.
package bankrf_pkg;

    localparam int PSR_W      = 32;
    localparam int MODE_W     = 5;
    localparam int FLAG_LSB   = 28;
    localparam int IMASK_BIT  = 7;
    localparam int FMASK_BIT  = 6;
    localparam int STATE_BIT  = 5;
    localparam int NUM_SAVED  = 5;
    localparam int SAVED_IW   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } mode_e;

    // True for any of the seven defined mode codes.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MODE_USR) || (m == MODE_SYS) || (m == MODE_FIQ) ||
               (m == MODE_IRQ) || (m == MODE_SVC) || (m == MODE_ABT) ||
               (m == MODE_UND);
    endfunction

    // True for modes that own a saved-status register.
    function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
               (m == MODE_ABT) || (m == MODE_UND);
    endfunction

    // Slot of the saved-status register owned by an exception mode.
    function automatic logic [SAVED_IW-1:0] saved_slot(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return 3'd0;
            MODE_IRQ: return 3'd1;
            MODE_SVC: return 3'd2;
            MODE_ABT: return 3'd3;
            MODE_UND: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

    // Bank of the stack/link pair: user and system share bank 0.
    function automatic int sl_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return 1;
            MODE_IRQ: return 2;
            MODE_SVC: return 3;
            MODE_ABT: return 4;
            MODE_UND: return 5;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/bankrf_mapper.sv
// Module: maps an architectural register index plus the current mode to a
// physical storage slot. Purely combinational.
// Layout: 0..7 common, 8..12 shared high, 13..17 fast-interrupt high,
// 18..29 stack/link pairs per bank, 30 program counter.
module bankrf_mapper
    import bankrf_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PHYS_W = 5
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [PHYS_W-1:0] phys_o
);
    localparam int LOW_LAST    = 7;
    localparam int HIGH_FIRST  = 8;
    localparam int HIGH_LAST   = 12;
    localparam int FIQ_BASE    = 13;
    localparam int SL_FIRST    = 13;
    localparam int SL_BASE     = 18;
    localparam int PC_IDX      = 15;
    localparam int PC_SLOT     = 30;

    int slot;

    // Select the physical slot for this index in this mode.
    always_comb begin
        slot = 0;
        if (int'(idx_i) <= LOW_LAST) begin
            slot = int'(idx_i);
        end else if (int'(idx_i) == PC_IDX) begin
            slot = PC_SLOT;
        end else if (int'(idx_i) <= HIGH_LAST) begin
            if (mode_i == MODE_FIQ)
                slot = FIQ_BASE + int'(idx_i) - HIGH_FIRST;
            else
                slot = int'(idx_i);
        end else begin
            slot = SL_BASE + 2 * sl_bank(mode_i) + int'(idx_i) - SL_FIRST;
        end
        phys_o = slot[PHYS_W-1:0];
    end

endmodule

// File: rtl/bankrf_store.sv
// Module: flat physical register storage with one write port and NUM_RD
// combinational read ports. Slots reset to zero.
// Assumes write and read addresses are already physical slots.
module bankrf_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    parameter int NUM_PHYS = 31,
    parameter int PHYS_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [PHYS_W-1:0]          wa_i,
    input  logic [DATA_W-1:0]          wd_i,
    input  logic [NUM_RD*PHYS_W-1:0]   ra_i,
    output logic [NUM_RD*DATA_W-1:0]   rd_o
);
    logic [DATA_W-1:0] slot_q [NUM_PHYS];

    // Storage update: clear on reset, else write the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_PHYS; s++) slot_q[s] <= '0;
        end else if (we_i) begin
            slot_q[wa_i] <= wd_i;
        end
    end

    genvar p;
    generate
        for (p = 0; p < NUM_RD; p++) begin : g_rd
            logic [PHYS_W-1:0] addr;
            assign addr = ra_i[p*PHYS_W +: PHYS_W];
            // Read mux for one port; out-of-range slots read zero.
            always_comb begin
                if (int'(addr) < NUM_PHYS)
                    rd_o[p*DATA_W +: DATA_W] = slot_q[addr];
                else
                    rd_o[p*DATA_W +: DATA_W] = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/bankrf_status.sv
// Module: current status word, per-exception-mode saved status, exception
// entry, software status writes and state-bit control.
// Assumes an accepted exception entry overrides any status write or
// branch-exchange presented in the same cycle.
module bankrf_status
    import bankrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flags_we_i,
    input  logic              ctrl_we_i,
    input  logic [PSR_W-1:0]  wdata_i,
    input  logic              exc_req_i,
    input  logic [MODE_W-1:0] exc_mode_i,
    input  logic              bx_en_i,
    input  logic              bx_state_i,
    output logic [PSR_W-1:0]  cpsr_o,
    output logic [PSR_W-1:0]  spsr_o,
    output logic [MODE_W-1:0] mode_o
);
    localparam int FLAG_W = PSR_W - FLAG_LSB;
    localparam int RSV_W  = FLAG_LSB - IMASK_BIT - 1;

    logic [FLAG_W-1:0] flags_q;
    logic              imask_q;
    logic              fmask_q;
    logic              state_q;
    logic [MODE_W-1:0] mode_q;
    logic [PSR_W-1:0]  saved_q [NUM_SAVED];
    logic              exc_take;
    logic              privileged;
    logic              unused_wdata;

    assign exc_take   = exc_req_i && is_exc_mode(exc_mode_i);
    assign privileged = (mode_q != MODE_USR);
    assign cpsr_o     = {flags_q, {RSV_W{1'b0}}, imask_q, fmask_q, state_q, mode_q};
    assign mode_o     = mode_q;
    assign unused_wdata = ^{wdata_i[FLAG_LSB-1:IMASK_BIT+1], wdata_i[STATE_BIT]};

    // Current status update: reset, exception entry, else software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            imask_q <= 1'b1;
            fmask_q <= 1'b1;
            state_q <= 1'b0;
            mode_q  <= MODE_SVC;
        end else if (exc_take) begin
            mode_q  <= exc_mode_i;
            imask_q <= 1'b1;
            if (exc_mode_i == MODE_FIQ) fmask_q <= 1'b1;
        end else begin
            if (flags_we_i) flags_q <= wdata_i[PSR_W-1:FLAG_LSB];
            if (ctrl_we_i && privileged) begin
                imask_q <= wdata_i[IMASK_BIT];
                fmask_q <= wdata_i[FMASK_BIT];
                if (mode_legal(wdata_i[MODE_W-1:0])) mode_q <= wdata_i[MODE_W-1:0];
            end
            if (bx_en_i) state_q <= bx_state_i;
        end
    end

    // Saved status: capture the old status word into the target's slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SAVED; s++) saved_q[s] <= '0;
        end else if (exc_take) begin
            saved_q[saved_slot(exc_mode_i)] <= cpsr_o;
        end
    end

    // Saved-status view for the current mode; zero where none exists.
    always_comb begin
        if (is_exc_mode(mode_q)) spsr_o = saved_q[saved_slot(mode_q)];
        else                     spsr_o = '0;
    end

endmodule

// File: rtl/banked_regfile.sv
// Module: top of the banked register file. Maps every access through the
// current mode, stores the registers and keeps the status words.
// Assumes register writes use the mode current at the clock edge.
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_RD = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_RD*4-1:0]       rd_idx_i,
    output logic [NUM_RD*DATA_W-1:0]  rd_data_o,
    input  logic                      wr_en_i,
    input  logic [3:0]                wr_idx_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      psr_wr_flags_i,
    input  logic                      psr_wr_ctrl_i,
    input  logic [31:0]               psr_wr_data_i,
    input  logic                      exc_req_i,
    input  logic [4:0]                exc_mode_i,
    input  logic                      bx_en_i,
    input  logic                      bx_state_i,
    output logic [31:0]               cpsr_o,
    output logic [31:0]               spsr_o
);
    localparam int IDX_W    = 4;
    localparam int NUM_PHYS = 31;
    localparam int PHYS_W   = $clog2(NUM_PHYS);

    logic [MODE_W-1:0]        cur_mode;
    logic [PHYS_W-1:0]        wr_phys;
    logic [NUM_RD*PHYS_W-1:0] rd_phys;

    bankrf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_we_i (psr_wr_flags_i),
        .ctrl_we_i  (psr_wr_ctrl_i),
        .wdata_i    (psr_wr_data_i),
        .exc_req_i  (exc_req_i),
        .exc_mode_i (exc_mode_i),
        .bx_en_i    (bx_en_i),
        .bx_state_i (bx_state_i),
        .cpsr_o     (cpsr_o),
        .spsr_o     (spsr_o),
        .mode_o     (cur_mode)
    );

    bankrf_mapper #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_wr_map (
        .idx_i  (wr_idx_i),
        .mode_i (cur_mode),
        .phys_o (wr_phys)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_RD; p++) begin : g_rd_map
            bankrf_mapper #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map (
                .idx_i  (rd_idx_i[p*IDX_W +: IDX_W]),
                .mode_i (cur_mode),
                .phys_o (rd_phys[p*PHYS_W +: PHYS_W])
            );
        end
    endgenerate

    bankrf_store #(
        .DATA_W   (DATA_W),
        .NUM_RD   (NUM_RD),
        .NUM_PHYS (NUM_PHYS),
        .PHYS_W   (PHYS_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_en_i),
        .wa_i  (wr_phys),
        .wd_i  (wr_data_i),
        .ra_i  (rd_phys),
        .rd_o  (rd_data_o)
    );

endmodule

// File: rtl/banked_regfile_checker.sv
// Module: temporal checks on the status behaviour of banked_regfile,
// attached by bind. Observes ports only.
module banked_regfile_checker
    import bankrf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic [4:0]  exc_mode,
    input logic        bx_en,
    input logic [31:0] cpsr,
    input logic [31:0] spsr
);
    // R8: without a branch-exchange strobe the state bit holds.
    p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_en |=> (cpsr[5] == $past(cpsr[5])));

    // R6: user mode without exception keeps masks and mode.
    p_user_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr[4:0] == MODE_USR && !exc_req) |=> $stable({cpsr[7:6], cpsr[4:0]}));

    // R9: accepted entry saves old status, loads mode, masks interrupts.
    p_exc_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && is_exc_mode(exc_mode)) |=>
            (cpsr[4:0] == $past(exc_mode)) && cpsr[7] && (spsr == $past(cpsr)));

    // R10: no saved status in user or system mode.
    p_spsr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr[4:0] == MODE_USR || cpsr[4:0] == MODE_SYS) |-> (spsr == 32'h0));

    // R12: reserved status bits read zero.
    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr[27:8] == 20'h0);

    // R7: the mode field never holds an undefined code.
    p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cpsr[4:0]));

endmodule

bind banked_regfile banked_regfile_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exc_req  (exc_req_i),
    .exc_mode (exc_mode_i),
    .bx_en    (bx_en_i),
    .cpsr     (cpsr_o),
    .spsr     (spsr_o)
);

// File: tb/banked_regfile_test.sv
// Directed bench for banked_regfile: one task per scenario.
module banked_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NR = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NR*4-1:0] rd_idx = '0;
    logic [NR*DW-1:0] rd_data;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_idx = '0;
    logic [DW-1:0]   wr_data = '0;
    logic            psr_flags = 1'b0;
    logic            psr_ctrl = 1'b0;
    logic [31:0]     psr_data = '0;
    logic            exc_req = 1'b0;
    logic [4:0]      exc_mode = '0;
    logic            bx_en = 1'b0;
    logic            bx_state = 1'b0;
    logic [31:0]     cpsr;
    logic [31:0]     spsr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile #(.DATA_W(DW), .NUM_RD(NR)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_idx_i       (rd_idx),
        .rd_data_o      (rd_data),
        .wr_en_i        (wr_en),
        .wr_idx_i       (wr_idx),
        .wr_data_i      (wr_data),
        .psr_wr_flags_i (psr_flags),
        .psr_wr_ctrl_i  (psr_ctrl),
        .psr_wr_data_i  (psr_data),
        .exc_req_i      (exc_req),
        .exc_mode_i     (exc_mode),
        .bx_en_i        (bx_en),
        .bx_state_i     (bx_state),
        .cpsr_o         (cpsr),
        .spsr_o         (spsr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive all strobes low at the current negedge.
    task automatic idle();
        wr_en = 1'b0; psr_flags = 1'b0; psr_ctrl = 1'b0;
        exc_req = 1'b0; bx_en = 1'b0;
    endtask

    task automatic write_reg(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic write_psr(input logic fl, input logic ct, input logic [31:0] d);
        @(negedge clk);
        psr_flags = fl; psr_ctrl = ct; psr_data = d;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic enter_exc(input logic [4:0] m);
        @(negedge clk);
        exc_req = 1'b1; exc_mode = m;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic branch_x(input logic v);
        @(negedge clk);
        bx_en = 1'b1; bx_state = v;
        @(negedge clk);
        idle();
        #1;
    endtask

    // Read on port 0 or port 1 and compare.
    task automatic check_reg(input string req, input int port, input logic [3:0] idx,
                             input logic [31:0] exp);
        rd_idx[port*4 +: 4] = idx;
        #1;
        check(req, rd_data[port*DW +: DW], exp);
    endtask

    task automatic t_reset();
        check("R1 status", cpsr, 32'h0000_00D3);
        check("R1 saved", spsr, 32'h0);
        check_reg("R1 r0", 0, 4'd0, 32'h0);
        check_reg("R1 r13", 1, 4'd13, 32'h0);
    endtask

    task automatic t_shared();
        write_reg(4'd3, 32'h1111_0003);
        write_reg(4'd15, 32'h0000_1000);
        write_psr(1'b0, 1'b1, 32'h0000_00D1);
        check("R2 mode fiq", cpsr, 32'h0000_00D1);
        check_reg("R2 r3", 0, 4'd3, 32'h1111_0003);
        check_reg("R2 r15", 1, 4'd15, 32'h0000_1000);
    endtask

    task automatic t_fiq_bank();
        write_reg(4'd8, 32'h0000_88F0);
        write_reg(4'd12, 32'h0000_C0F0);
        write_psr(1'b0, 1'b1, 32'h0000_00DF);
        check_reg("R3 sys r8", 0, 4'd8, 32'h0);
        write_reg(4'd8, 32'h0000_8800);
        write_psr(1'b0, 1'b1, 32'h0000_00D1);
        check_reg("R3 fiq r8", 0, 4'd8, 32'h0000_88F0);
        check_reg("R3 fiq r12", 1, 4'd12, 32'h0000_C0F0);
        write_psr(1'b0, 1'b1, 32'h0000_00D2);
        check_reg("R3 irq r8", 0, 4'd8, 32'h0000_8800);
    endtask

    task automatic t_sl_bank();
        write_psr(1'b0, 1'b1, 32'h0000_00DF);
        write_reg(4'd13, 32'h0000_00D5);
        write_reg(4'd14, 32'h0000_00E5);
        write_psr(1'b0, 1'b1, 32'h0000_00D3);
        check_reg("R4 svc r13", 0, 4'd13, 32'h0);
        write_reg(4'd13, 32'h0000_D3D3);
        write_psr(1'b0, 1'b1, 32'h0000_00D2);
        check_reg("R4 irq r13", 0, 4'd13, 32'h0);
        check_reg("R4 irq r14", 1, 4'd14, 32'h0);
        write_psr(1'b0, 1'b1, 32'h0000_00DF);
        check_reg("R4 sys r13", 0, 4'd13, 32'h0000_00D5);
    endtask

    task automatic t_write_at_switch();
        write_psr(1'b0, 1'b1, 32'h0000_00D3);
        @(negedge clk);
        psr_ctrl = 1'b1; psr_data = 32'h0000_00D2;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0000_AAAA;
        @(negedge clk);
        idle();
        #1;
        check("R13 now irq", cpsr, 32'h0000_00D2);
        check_reg("R13 irq r13", 0, 4'd13, 32'h0);
        write_psr(1'b0, 1'b1, 32'h0000_00D3);
        check_reg("R13 svc r13", 0, 4'd13, 32'h0000_AAAA);
        write_psr(1'b0, 1'b1, 32'h0000_00DF);
    endtask

    task automatic t_flags();
        write_psr(1'b1, 1'b0, 32'hA5A5_A500);
        check("R5 R12 flags only", cpsr, 32'hA000_00DF);
    endtask

    task automatic t_illegal_mode();
        write_psr(1'b0, 1'b1, 32'h0000_0015);
        check("R7 illegal mode", cpsr, 32'hA000_001F);
    endtask

    task automatic t_state();
        write_psr(1'b1, 1'b1, 32'hA000_00FF);
        check("R8 write keeps state", cpsr, 32'hA000_00DF);
        branch_x(1'b1);
        check("R8 bx set", cpsr, 32'hA000_00FF);
        branch_x(1'b0);
        check("R8 bx clear", cpsr, 32'hA000_00DF);
        branch_x(1'b1);
    endtask

    task automatic t_exception();
        write_psr(1'b0, 1'b1, 32'h0000_003F);
        check("R7 masks cleared", cpsr, 32'hA000_003F);
        enter_exc(5'h12);
        check("R9 irq entry status", cpsr, 32'hA000_00B2);
        check("R9 irq saved", spsr, 32'hA000_003F);
        write_psr(1'b0, 1'b1, 32'h0000_0017);
        check("R9 sw change status", cpsr, 32'hA000_0037);
        check("R9 sw change no save", spsr, 32'h0);
        enter_exc(5'h11);
        check("R9 fiq entry status", cpsr, 32'hA000_00F1);
        check("R9 fiq saved", spsr, 32'hA000_0037);
        branch_x(1'b0);
    endtask

    task automatic t_user();
        write_psr(1'b0, 1'b1, 32'h0000_0010);
        check("R6 enter user", cpsr, 32'hA000_0010);
        check("R10 user saved", spsr, 32'h0);
        write_psr(1'b0, 1'b1, 32'h0000_00DF);
        check("R6 user ctrl ignored", cpsr, 32'hA000_0010);
        write_psr(1'b1, 1'b0, 32'h5000_0000);
        check("R5 user flags", cpsr, 32'h5000_0010);
        check_reg("R4 user r13", 1, 4'd13, 32'h0000_00D5);
    endtask

    task automatic t_collide();
        @(negedge clk);
        exc_req = 1'b1; exc_mode = 5'h13;
        psr_flags = 1'b1; psr_ctrl = 1'b1; psr_data = 32'hF000_00DF;
        bx_en = 1'b1; bx_state = 1'b1;
        @(negedge clk);
        idle();
        #1;
        check("R11 entry wins", cpsr, 32'h5000_0093);
        check("R11 svc saved", spsr, 32'h5000_0010);
        enter_exc(5'h1F);
        check("R11 sys target ignored", cpsr, 32'h5000_0093);
        enter_exc(5'h14);
        check("R11 bad target ignored", cpsr, 32'h5000_0093);
        write_psr(1'b0, 1'b1, 32'h0000_001F);
        check("R10 sys saved", spsr, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_shared();
        t_fiq_bank();
        t_sl_bank();
        t_write_at_switch();
        t_flags();
        t_illegal_mode();
        t_state();
        t_exception();
        t_user();
        t_collide();
        summary();
    end

endmodule